// File: doc/BRIEF.md
# SD card clock generator

This block turns a kernel clock into the clock that is driven to an SD card, and tells the command and data shift logic when to put new values on the bus. A 32-bit control word sets how the card clock is built. It selects an even divide ratio, where the card clock period is twice the divide field in kernel cycles. A divide field of zero passes the kernel clock straight through. The control word also holds an idle gating enable, the bus width, the launch-edge choice and double data rate signalling.

Software writes the control word through a simple write port and reads it back on a parallel output. A write lands only when the command engine and the data engine both report that they are idle. Otherwise the write is dropped without any indication.

All card clock edges are made on kernel rising edges. Any change to the divide ratio, launch edge or data rate waits for a point where the card clock is low, so the card never sees a shortened pulse. The launch strobes are one kernel cycle wide. A shift register that updates on the kernel falling edge uses them with the default edge choice. A shift register that updates on the kernel rising edge uses them when the opposite edge is selected.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the control word reads 0x00000000, the divide field is zero, and from the first kernel falling edge after reset the card clock is a gated copy of the kernel clock.
- R2: A write with both busy flags low updates the control word on the next rising edge. It keeps only bits 9:0 (divide), 12 (idle gating), 15:14 (bus width), 16 (launch edge), 17, 18 (double rate), 19 and 21:20. Every other bit reads back as zero.
- R3: A write made while the command busy flag or the data busy flag is high is discarded, and the readback keeps its old value.
- R4: With a divide field N greater than zero and gating inactive, the card clock stays high for N kernel cycles and then low for N kernel cycles.
- R5: With a divide field of zero, the card clock equals the kernel clock and both launch strobes are high in every kernel cycle.
- R6: When the idle gating bit 12 is set and the bus idle input is high, the card clock finishes its high phase and then stays low. When the clock resumes, it starts with a full low phase of N cycles.
- R7: With launch edge bit 16 clear, both strobes are high in the kernel cycle that begins with a card clock rising edge.
- R8: With launch edge bit 16 set and N greater than zero, both strobes are high in the kernel cycle whose closing rising edge makes the card clock fall.
- R9: Double rate is in effect when bit 18 is set, bits 15:14 are nonzero and N is greater than zero. The command strobe is unchanged. The data strobe also fires once for the opposite card edge: in the cycle after a fall when bit 16 is clear, and in the cycle before a rise when bit 16 is set.
- R10: Bit 18 has no effect while bits 15:14 are 00.
- R11: A new divide value, launch edge or data rate takes effect only when the card clock is low: at a falling edge, while the clock is stopped, or while the divider is bypassed.
- R12: Entry to and exit from pass-through mode switch only while the kernel clock is low, and the divided clock is never high while pass-through is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Control word readback |
| cmd_busy | input | 1 | Command engine active |
| dat_busy | input | 1 | Data engine active |
| bus_idle | input | 1 | Bus has no traffic; stops the clock when gating is enabled |
| card_clk | output | 1 | Clock to the card |
| cmd_launch | output | 1 | Command launch strobe |
| dat_launch | output | 1 | Data launch strobe |

## Verification
Two events can fall in the same kernel cycle and interfere. One is a control write landing. The other is the divider reloading its active settings at a card clock fall or while the clock is stopped. The bench issues writes while the card clock is high, at the fall and in the middle of a low phase, and toggles bus idle around the end of a high phase. A behavioural reference model then decides, on every kernel edge, which settings the following card cycle must use. Each card clock level, strobe and readback value is compared against the model in both kernel clock phases.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  localparam int CFG_W     = 32;
  localparam int DIV_W     = 10;

  // bit positions that software relies on
  localparam int DIV_LSB   = 0;
  localparam int GATE_BIT  = 12;
  localparam int WID_LSB   = 14;
  localparam int EDGE_BIT  = 16;
  localparam int FLOW_BIT  = 17;
  localparam int DRATE_BIT = 18;
  localparam int SPEED_BIT = 19;
  localparam int RXS_LSB   = 20;

  localparam logic [CFG_W-1:0] CFG_MASK = 32'h003F_D3FF;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             gate;
    logic [1:0]       width;
    logic             edge_sel;
    logic             drate;
  } clk_cfg_t;

endpackage

// File: rtl/sdclk_cfg_reg.sv
module sdclk_cfg_reg
  import sdclk_pkg::*;
#(
  parameter int DATA_W = CFG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cmd_busy,
  input  logic              dat_busy,
  output logic [DATA_W-1:0] word,
  output clk_cfg_t          cfg
);

  localparam logic [DATA_W-1:0] KEEP = DATA_W'(CFG_MASK);

  logic              accept;
  logic [DATA_W-1:0] word_q;

  assign accept = we && !cmd_busy && !dat_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (accept) begin
      word_q <= wdata & KEEP;
    end
  end

  assign word         = word_q;
  assign cfg.div      = word_q[DIV_LSB +: DIV_W];
  assign cfg.gate     = word_q[GATE_BIT];
  assign cfg.width    = word_q[WID_LSB +: 2];
  assign cfg.edge_sel = word_q[EDGE_BIT];
  assign cfg.drate    = word_q[DRATE_BIT];

  // R3: a write during activity leaves the word untouched
  p_locked_r3 : assert property (@(posedge clk) disable iff (rst)
    (cmd_busy || dat_busy) |=> $stable(word_q));

  // R2: an accepted write is visible on the next edge
  p_accept_r2 : assert property (@(posedge clk) disable iff (rst)
    (we && !cmd_busy && !dat_busy) |=> (word_q == ($past(wdata) & KEEP)));

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic     clk,
  input  logic     rst,
  input  clk_cfg_t cfg,
  input  logic     run,
  output logic     ck_q,
  output logic     cmd_q,
  output logic     dat_q,
  output logic     act_zero
);

  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] act_div_q, act_div_d;
  logic          act_edge_q, act_edge_d;
  logic          act_dr_q, act_dr_d;
  logic          ck_d;
  logic          reload;
  logic          phase_end;
  logic          rise, fall;
  logic          pre_fall, pre_rise;
  logic          cmd_d, dat_d;

  assign phase_end = (cnt_q == act_div_q - ONE);

  always_comb begin
    ck_d   = ck_q;
    cnt_d  = cnt_q;
    reload = 1'b0;
    if (act_div_q == '0) begin
      ck_d   = 1'b0;
      cnt_d  = '0;
      reload = 1'b1;
    end else if (!ck_q && !run) begin
      cnt_d  = '0;
      reload = 1'b1;
    end else if (phase_end) begin
      ck_d   = !ck_q;
      cnt_d  = '0;
      reload = ck_q;
    end else begin
      cnt_d  = cnt_q + ONE;
    end
  end

  always_comb begin
    act_div_d  = act_div_q;
    act_edge_d = act_edge_q;
    act_dr_d   = act_dr_q;
    if (reload) begin
      act_div_d  = cfg.div;
      act_edge_d = cfg.edge_sel;
      act_dr_d   = cfg.drate && (cfg.width != 2'b00);
    end
  end

  assign rise     = !ck_q && ck_d;
  assign fall     = ck_q && !ck_d;
  assign pre_fall = ck_d && (cnt_d == act_div_d - ONE);
  assign pre_rise = !ck_d && (act_div_d != '0) && (cnt_d == act_div_d - ONE) && run;

  always_comb begin
    if (!act_edge_d) begin
      cmd_d = rise;
      dat_d = rise || (act_dr_d && fall);
    end else begin
      cmd_d = pre_fall;
      dat_d = pre_fall || (act_dr_d && pre_rise);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q       <= 1'b0;
      cnt_q      <= '0;
      act_div_q  <= '0;
      act_edge_q <= 1'b0;
      act_dr_q   <= 1'b0;
      cmd_q      <= 1'b0;
      dat_q      <= 1'b0;
    end else begin
      ck_q       <= ck_d;
      cnt_q      <= cnt_d;
      act_div_q  <= act_div_d;
      act_edge_q <= act_edge_d;
      act_dr_q   <= act_dr_d;
      cmd_q      <= cmd_d;
      dat_q      <= dat_d;
    end
  end

  assign act_zero = (act_div_q == '0);

  // R4: phase counter never passes the active half period
  p_cnt_range_r4 : assert property (@(posedge clk) disable iff (rst)
    (act_div_q != '0) |-> (cnt_q < act_div_q));

  // R11: active settings only move while the card clock is low
  p_no_runt_r11 : assert property (@(posedge clk) disable iff (rst)
    !$stable(act_div_q) |-> !ck_q);

  // R6: a stopped clock stays low
  p_stop_low_r6 : assert property (@(posedge clk) disable iff (rst)
    (!run && !ck_q) |=> !ck_q);

  // R9: a command launch always comes with a data launch
  p_cmd_dat_r9 : assert property (@(posedge clk) disable iff (rst)
    cmd_q |-> dat_q);

  // R5: the divided clock idles while bypassed
  p_bypass_low_r5 : assert property (@(posedge clk) disable iff (rst)
    (act_div_q == '0) |=> !ck_q);

endmodule

// File: rtl/sdclk_bypass_gate.sv
module sdclk_bypass_gate (
  input  logic clk,
  input  logic rst,
  input  logic act_zero,
  input  logic run,
  input  logic ck_q,
  output logic byp_en,
  output logic card_clk
);

  // enable moves only on the kernel falling edge, while clk is low
  always_ff @(negedge clk) begin
    if (rst) begin
      byp_en <= 1'b0;
    end else begin
      byp_en <= act_zero && run;
    end
  end

  assign card_clk = byp_en ? clk : ck_q;

  // R12: pass-through and divided clock never overlap
  p_gate_excl_r12 : assert property (@(posedge clk) disable iff (rst)
    byp_en |-> !ck_q);

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int DATA_W = CFG_W,
  parameter int DW     = DIV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              cmd_busy,
  input  logic              dat_busy,
  input  logic              bus_idle,
  output logic              card_clk,
  output logic              cmd_launch,
  output logic              dat_launch
);

  clk_cfg_t cfg;
  logic     run;
  logic     ck_q, cmd_q, dat_q;
  logic     act_zero;
  logic     byp_en;

  sdclk_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .cmd_busy (cmd_busy),
    .dat_busy (dat_busy),
    .word     (cfg_rdata),
    .cfg      (cfg)
  );

  assign run = !(cfg.gate && bus_idle);

  sdclk_divider #(.DW(DW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfg),
    .run      (run),
    .ck_q     (ck_q),
    .cmd_q    (cmd_q),
    .dat_q    (dat_q),
    .act_zero (act_zero)
  );

  sdclk_bypass_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .act_zero (act_zero),
    .run      (run),
    .ck_q     (ck_q),
    .byp_en   (byp_en),
    .card_clk (card_clk)
  );

  assign cmd_launch = byp_en | cmd_q;
  assign dat_launch = byp_en | dat_q;

  // R7: with the default edge a divided command launch sits in a high phase
  p_launch_high_r7 : assert property (@(posedge clk) disable iff (rst)
    (cmd_q && !cfg.edge_sel && $stable(cfg) && !act_zero) |-> ck_q);

endmodule

// File: tb/sim_sdclk_gen.sv
module sim_sdclk_gen;

  localparam int MASK = 32'h003F_D3FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cmd_busy = 1'b0;
  logic        dat_busy = 1'b0;
  logic        bus_idle = 1'b0;
  logic        card_clk, cmd_launch, dat_launch;

  always #4 clk = !clk;  // 125 MHz

  sdclk_gen u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cmd_busy(cmd_busy), .dat_busy(dat_busy),
    .bus_idle(bus_idle), .card_clk(card_clk), .cmd_launch(cmd_launch),
    .dat_launch(dat_launch)
  );

  int    vectors = 0;
  int    misses  = 0;
  string cur_req = "R1";
  bit    done    = 0;

  // behavioural reference
  int m_cfg = 0, m_lvl = 0, m_cnt = 0, m_ad = 0;
  bit m_edge = 0, m_ddr = 0, m_cq = 0, m_dq = 0, m_byp = 0;

  always @(posedge clk) begin
    int oc, ol;
    bit go, rl, r, f, pf, pr;
    if (rst) begin
      m_cfg = 0; m_lvl = 0; m_cnt = 0; m_ad = 0;
      m_edge = 0; m_ddr = 0; m_cq = 0; m_dq = 0;
    end else begin
      oc = m_cfg;
      go = !(((oc >> 12) & 1) == 1 && bus_idle);
      if (cfg_we && !cmd_busy && !dat_busy) m_cfg = int'(cfg_wdata) & MASK;
      ol = m_lvl;
      rl = 0;
      if (m_ad == 0) begin m_lvl = 0; m_cnt = 0; rl = 1; end
      else if (m_lvl == 0 && !go) begin m_cnt = 0; rl = 1; end
      else if (m_cnt == m_ad - 1) begin
        m_lvl = 1 - m_lvl; m_cnt = 0;
        if (m_lvl == 0) rl = 1;
      end else m_cnt++;
      if (rl) begin
        m_ad   = oc & 32'h3FF;
        m_edge = ((oc >> 16) & 1) == 1;
        m_ddr  = ((oc >> 18) & 1) == 1 && ((oc >> 14) & 3) != 0;
      end
      r = (ol == 0 && m_lvl == 1);
      f = (ol == 1 && m_lvl == 0);
      if (!m_edge) begin
        m_cq = r; m_dq = r || (m_ddr && f);
      end else begin
        pf = (m_lvl == 1 && m_cnt == m_ad - 1);
        pr = (m_lvl == 0 && m_ad != 0 && m_cnt == m_ad - 1 && go);
        m_cq = pf; m_dq = pf || (m_ddr && pr);
      end
    end
  end

  always @(negedge clk) begin
    if (rst) m_byp = 0;
    else m_byp = (m_ad == 0) && !(((m_cfg >> 12) & 1) == 1 && bus_idle);
  end

  task automatic chk(input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare during the high kernel phase
  always @(posedge clk) begin
    #3;
    if (!rst && !done) begin
      chk("readback", int'(cfg_rdata), m_cfg);
      chk("card_clk hi", int'(card_clk), (m_byp || m_lvl == 1) ? 1 : 0);
      chk("cmd_launch", int'(cmd_launch), (m_byp || m_cq) ? 1 : 0);
      chk("dat_launch", int'(dat_launch), (m_byp || m_dq) ? 1 : 0);
    end
  end

  // compare during the low kernel phase
  always @(negedge clk) begin
    #3;
    if (!rst && !done) chk("card_clk lo", int'(card_clk), m_lvl);
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic put(input logic [31:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  initial begin
    #400000;
    misses++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    cur_req = "R1";                     // reset word zero, pass-through
    wait_cyc(6);

    cur_req = "R4";                     // div 3, edge clear (R7)
    put(32'h0000_0003);
    wait_cyc(30);
    cur_req = "R7";
    wait_cyc(12);

    cur_req = "R3";                     // writes under activity dropped
    cmd_busy = 1'b1; put(32'h0000_0005); cmd_busy = 1'b0;
    dat_busy = 1'b1; put(32'h0001_0001); dat_busy = 1'b0;
    cmd_busy = 1'b1; dat_busy = 1'b1; put(32'h0000_0002);
    cmd_busy = 1'b0; dat_busy = 1'b0;
    wait_cyc(10);

    cur_req = "R8";                     // div 1, edge set
    put(32'h0001_0001);
    wait_cyc(20);
    put(32'h0001_0004);
    wait_cyc(24);

    cur_req = "R9";                     // double rate, width 01
    put(32'h0004_4002);
    wait_cyc(30);
    put(32'h0005_4002);
    wait_cyc(30);
    put(32'h0005_8003);
    wait_cyc(30);

    cur_req = "R10";                    // double rate with width 00
    put(32'h0004_0002);
    wait_cyc(24);
    put(32'h0005_0002);
    wait_cyc(24);

    cur_req = "R6";                     // idle gating
    put(32'h0000_1004);
    for (int k = 0; k < 10; k++) begin
      bus_idle = 1'b1; wait_cyc(3 + k);
      bus_idle = 1'b0; wait_cyc(2 + (k % 5));
    end
    bus_idle = 1'b0;
    wait_cyc(10);

    cur_req = "R11";                    // settings change mid phase
    for (int k = 0; k < 8; k++) begin
      put(32'h0000_0001 + 32'(k % 4) + ((k % 2) << 16));
      wait_cyc(k + 1);
    end
    wait_cyc(20);

    cur_req = "R2";                     // reserved bits read zero
    put(32'hFFC0_0C00);
    wait_cyc(4);
    put(32'h003E_0003);
    wait_cyc(12);

    cur_req = "R5";                     // back to pass-through
    put(32'h0000_0000);
    wait_cyc(10);
    cur_req = "R12";                    // gated pass-through
    put(32'h0000_1000);
    for (int k = 0; k < 6; k++) begin
      bus_idle = 1'b1; wait_cyc(2 + k);
      bus_idle = 1'b0; wait_cyc(3);
    end
    cur_req = "R11";                    // leave pass-through
    put(32'h0000_0002);
    wait_cyc(16);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule